// File: doc/BRIEF.md
# Dual-Mode Timer with Event Output Pin

This block is a 32-bit up-counter for general timing work. Software controls it through a small register file with word addresses. A start bit gates counting. A power-of-two prescaler can be placed in front of the counter. On overflow the counter either reloads from a load register or stops after one pass. A comparator raises a match event, and an overflow raises an overflow event. Both events are latched in a status register that drives an interrupt output and a wakeup output, each through its own mask. An output pin can pulse or toggle on selected events.

Writes to the control, counter, load, match and trigger registers are posted. Each of these registers has a three-state posting machine: `PS_IDLE`, then `PS_WAIT` on an accepted write, then `PS_COMMIT`, then back to `PS_IDLE`, which is the cycle the value lands. While the machine is out of `PS_IDLE`, the register's pending flag is high and any further write to that register is dropped. A run machine moves from `RUN_OFF` to `RUN_ON` when a committed control word has the start bit set. It returns to `RUN_OFF` when a committed control word has the start bit clear, or when an overflow ends a one-shot pass. A pulse machine moves from `PW_REST` to `PW_PULSE` on a selected event and back to `PW_REST` on the next prescaled tick that carries no event.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset every readable register reads 0, and `irq_out`, `wake_out` and `pwm_out` are 0.
- R2: Word addresses: 0 control, 1 counter, 2 load, 3 match, 4 trigger (write-only, reads 0), 5 status, 6 interrupt enable, 7 interrupt disable (reads 0), 8 wakeup enable, 9 pending flags (bit i is the flag for address i, for i in 0..4). A write to addresses 0..4 raises that register's pending flag for the two following cycles and takes effect at the second clock edge after the write edge. A write to a register whose flag is high is lost.
- R3: Control bit 0 (start) enables counting. While it reads 0, the counter holds its value.
- R4: Control bit 5 enables the prescaler, and control bits 4:2 hold the ratio r. When enabled, the counter advances once every 2^(r+1) clocks. When disabled, it advances every clock.
- R5: When the counter advances from 0xFFFFFFFF and control bit 1 (auto-reload) is set, the counter takes the load value. Every such overflow sets status bit 1.
- R6: When the counter overflows with auto-reload clear, it becomes 0 and the start bit clears, unless a control commit lands on the same edge.
- R7: A write of any data to the trigger register copies the load register into the counter when the write commits. This takes precedence over a counter commit and over counting.
- R8: With control bit 6 (compare enable) set, a counter advance whose new value equals the match register sets status bit 0.
- R9: Status bits stay set until a 1 is written to them at address 5. A write to address 6 replaces the 2-bit interrupt mask, and a write to address 7 clears the mask bits written as 1. `irq_out` is high when any status bit is set together with its mask bit.
- R10: `wake_out` is high when any status bit is set together with its bit in the wakeup-enable register (address 8).
- R11: Control bits 11:10 select which events drive the pin: 01 selects overflow, 10 selects overflow or match, and 00 or 11 select none. Control bit 7 is the pin's resting level.
- R12: With control bit 12 clear, a selected event inverts the pin from its resting level for one prescaled tick. With bit 12 set, each selected event toggles the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Masked status interrupt |
| wake_out | output | 1 | Masked status wakeup |
| pwm_out | output | 1 | Event output pin |

## Verification
A posted write lands two edges after its write edge, and its pending flag reads high during exactly the two cycles in between. Status, mask and wakeup-enable writes, counter advances and pin changes all appear right after the edge that causes them. `irq_out` and `wake_out` follow the status in the same cycle. The bench drives inputs just after the falling edge and runs a behavioural model that takes one step per rising edge from those inputs. At each falling edge it compares the read data for the current address and all three outputs against the model, so every result is checked in the cycle it is due. Directed reads add fixed expected values for the posted-write loss, the trigger copy, the frozen counter, the one-shot stop and the pin pulse and toggle counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // register word addresses; posted lanes share their address as index
    localparam int A_CTRL  = 0;
    localparam int A_COUNT = 1;
    localparam int A_LOAD  = 2;
    localparam int A_MATCH = 3;
    localparam int A_TRIG  = 4;
    localparam int A_STAT  = 5;
    localparam int A_IEN   = 6;
    localparam int A_IDIS  = 7;
    localparam int A_WAKE  = 8;
    localparam int A_WPEND = 9;
    localparam int NLANE   = 5;

    // control bit positions
    localparam int B_START = 0;
    localparam int B_AR    = 1;
    localparam int B_RLO   = 2;
    localparam int B_RHI   = 4;
    localparam int B_PRE   = 5;
    localparam int B_CE    = 6;
    localparam int B_DEF   = 7;
    localparam int B_TLO   = 10;
    localparam int B_THI   = 11;
    localparam int B_TOG   = 12;
    localparam int CTRL_W  = 13;

    // status bits
    localparam int S_MATCH = 0;
    localparam int S_OVF   = 1;
    localparam int EV_W    = 2;

    typedef enum logic [1:0] {PS_IDLE, PS_WAIT, PS_COMMIT} post_st_t;
    typedef enum logic {RUN_OFF, RUN_ON} run_st_t;
    typedef enum logic {PW_REST, PW_PULSE} pulse_st_t;
    typedef enum logic [1:0] {TS_NONE = 2'b00, TS_OVF = 2'b01,
                              TS_BOTH = 2'b10, TS_RSVD = 2'b11} tsel_t;
endpackage

// File: rtl/tmr_post_lane.sv
module tmr_post_lane
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          commit,
    output logic [DW-1:0] hold
);
    post_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_IDLE:   if (wr_req) st_d = PS_WAIT;
            PS_WAIT:   st_d = PS_COMMIT;
            PS_COMMIT: st_d = PS_IDLE;
            default:   st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        hold <= '0;
        else if (st_q == PS_IDLE && wr_req) hold <= wr_data;
    end

    always_comb begin
        pending = (st_q != PS_IDLE);
        commit  = (st_q == PS_COMMIT);
    end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pre_en,
    input  logic [RW-1:0] ratio,
    output logic          tick
);
    localparam int PW = 1 << RW;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] div_m1;
    logic [PW:0]   span;

    always_comb begin
        span   = (PW+1)'(1) << (32'(ratio) + 1);
        div_m1 = pre_en ? PW'(span - 1'b1) : '0;
        tick   = run && (pcnt >= div_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pcnt <= '0;
        else if (!run || tick) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       ovf_ev,
    input  logic       mt_ev,
    input  logic [1:0] tsel,
    input  logic       def_lvl,
    input  logic       tog_mode,
    output logic       pin
);
    tsel_t     ts;
    logic      ev;
    logic      armed;
    pulse_st_t pst_q, pst_d;
    logic      tog_q;

    always_comb begin
        ts = tsel_t'(tsel);
        unique case (ts)
            TS_OVF:  begin ev = ovf_ev;          armed = 1'b1; end
            TS_BOTH: begin ev = ovf_ev | mt_ev;  armed = 1'b1; end
            default: begin ev = 1'b0;            armed = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pst_q <= PW_REST;
        else        pst_q <= pst_d;
    end

    always_comb begin
        pst_d = pst_q;
        unique case (pst_q)
            PW_REST:  if (run && tick && ev) pst_d = PW_PULSE;
            PW_PULSE: begin
                if (!run)             pst_d = PW_REST;
                else if (tick && !ev) pst_d = PW_REST;
            end
            default:  pst_d = PW_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tog_q <= 1'b0;
        else if (!armed) tog_q <= 1'b0;
        else if (ev)     tog_q <= ~tog_q;
    end

    always_comb begin
        pin = def_lvl ^ (tog_mode ? tog_q : (pst_q == PW_PULSE));
    end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import tmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_out,
    output logic          wake_out,
    output logic          pwm_out
);
    logic [NLANE-1:0] wr_req;
    logic [NLANE-1:0] pend;
    logic [NLANE-1:0] cmt;
    logic [DW-1:0]    hold [NLANE];

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign wr_req[i] = bus_wr && (int'(bus_addr) == i);
        tmr_post_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_req  (wr_req[i]),
            .wr_data (bus_wdata),
            .pending (pend[i]),
            .commit  (cmt[i]),
            .hold    (hold[i])
        );
    end

    logic unused_ok;
    assign unused_ok = ^{hold[A_CTRL][DW-1:CTRL_W], hold[A_TRIG]};

    logic [CTRL_W-1:1] ctrl_q;
    logic [DW-1:0]     cnt_q, load_q, match_q;
    logic [EV_W-1:0]   stat_q, ien_q, wake_q;
    run_st_t           run_q, run_d;
    logic              tick;
    logic              cnt_max;
    logic [DW-1:0]     cnt_inc;
    logic              ovf_ev, mt_ev;
    logic [EV_W-1:0]   w1c;

    tmr_prescale #(.RW(RW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q == RUN_ON),
        .pre_en (ctrl_q[B_PRE]),
        .ratio  (ctrl_q[B_RHI:B_RLO]),
        .tick   (tick)
    );

    always_comb begin
        cnt_max = &cnt_q;
        cnt_inc = cnt_max ? (ctrl_q[B_AR] ? load_q : '0) : cnt_q + 1'b1;
        ovf_ev  = tick && cnt_max;
        mt_ev   = tick && ctrl_q[B_CE] && (cnt_inc == match_q);
        w1c     = (bus_wr && int'(bus_addr) == A_STAT) ? bus_wdata[EV_W-1:0] : '0;
    end

    // run state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= RUN_OFF;
        else        run_q <= run_d;
    end

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_OFF: if (cmt[A_CTRL] && hold[A_CTRL][B_START]) run_d = RUN_ON;
            RUN_ON: begin
                if (cmt[A_CTRL]) begin
                    if (!hold[A_CTRL][B_START]) run_d = RUN_OFF;
                end else if (ovf_ev && !ctrl_q[B_AR]) begin
                    run_d = RUN_OFF;
                end
            end
            default: run_d = RUN_OFF;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            load_q  <= '0;
            match_q <= '0;
            stat_q  <= '0;
            ien_q   <= '0;
            wake_q  <= '0;
        end else begin
            if (cmt[A_CTRL])  ctrl_q  <= hold[A_CTRL][CTRL_W-1:1];
            if (cmt[A_LOAD])  load_q  <= hold[A_LOAD];
            if (cmt[A_MATCH]) match_q <= hold[A_MATCH];

            if (cmt[A_TRIG])       cnt_q <= load_q;
            else if (cmt[A_COUNT]) cnt_q <= hold[A_COUNT];
            else if (tick)         cnt_q <= cnt_inc;

            stat_q <= (stat_q & ~w1c) | {ovf_ev, mt_ev};

            if (bus_wr && int'(bus_addr) == A_IEN)       ien_q <= bus_wdata[EV_W-1:0];
            else if (bus_wr && int'(bus_addr) == A_IDIS) ien_q <= ien_q & ~bus_wdata[EV_W-1:0];

            if (bus_wr && int'(bus_addr) == A_WAKE) wake_q <= bus_wdata[EV_W-1:0];
        end
    end

    tmr_pwm u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q == RUN_ON),
        .tick     (tick),
        .ovf_ev   (ovf_ev),
        .mt_ev    (mt_ev),
        .tsel     (ctrl_q[B_THI:B_TLO]),
        .def_lvl  (ctrl_q[B_DEF]),
        .tog_mode (ctrl_q[B_TOG]),
        .pin      (pwm_out)
    );

    // outputs
    always_comb begin
        irq_out  = |(stat_q & ien_q);
        wake_out = |(stat_q & wake_q);
        bus_rdata = '0;
        case (int'(bus_addr))
            A_CTRL:  bus_rdata = DW'({ctrl_q, run_q == RUN_ON});
            A_COUNT: bus_rdata = cnt_q;
            A_LOAD:  bus_rdata = load_q;
            A_MATCH: bus_rdata = match_q;
            A_STAT:  bus_rdata = DW'(stat_q);
            A_IEN:   bus_rdata = DW'(ien_q);
            A_WAKE:  bus_rdata = DW'(wake_q);
            A_WPEND: bus_rdata = DW'(pend);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_mode_timer_chk.sv
module dual_mode_timer_chk
    import tmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [NLANE-1:0] pend,
    input logic [NLANE-1:0] cmt,
    input logic             run_on,
    input logic             tick,
    input logic             auto_rl,
    input logic [DW-1:0]    cnt_q,
    input logic [EV_W-1:0]  stat_q
);
    for (genvar i = 0; i < NLANE; i++) begin : g_pend
        // R2
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |=> pend[i] ##1 !pend[i]);
    end

    // R3
    cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !cmt[A_COUNT] && !cmt[A_TRIG]) |=> $stable(cnt_q));

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_on);

    // R5
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&cnt_q)) |=> stat_q[S_OVF]);

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&cnt_q) && !auto_rl && !cmt[A_CTRL] && !cmt[A_COUNT] && !cmt[A_TRIG])
        |=> (!run_on && cnt_q == '0));

    // R9
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[S_OVF] && !(bus_wr && int'(bus_addr) == A_STAT && bus_wdata[S_OVF]))
        |=> stat_q[S_OVF]);
endmodule

bind dual_mode_timer dual_mode_timer_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend),
    .cmt       (cmt),
    .run_on    (run_q == tmr_pkg::RUN_ON),
    .tick      (tick),
    .auto_rl   (ctrl_q[tmr_pkg::B_AR]),
    .cnt_q     (cnt_q),
    .stat_q    (stat_q)
);

// File: tb/dual_mode_timer_test.sv
`timescale 1ns/1ps
module dual_mode_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, wake_out, pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_mode_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .wake_out(wake_out), .pwm_out(pwm_out)
    );

    // behavioural reference model
    bit [31:0] m_cnt, m_load, m_match;
    bit [12:0] m_ctrl;
    int        m_pend [5];
    bit [31:0] m_pdata [5];
    int        m_pre;
    bit [1:0]  m_stat, m_en, m_wk;
    bit        m_pulse, m_tog;

    function automatic bit m_pin();
        return m_ctrl[7] ^ (m_ctrl[12] ? m_tog : m_pulse);
    endfunction

    function automatic bit [31:0] m_read(int a);
        bit [31:0] pv = 0;
        for (int i = 0; i < 5; i++) pv[i] = (m_pend[i] != 0);
        case (a)
            0: return {19'd0, m_ctrl};
            1: return m_cnt;
            2: return m_load;
            3: return m_match;
            5: return {30'd0, m_stat};
            6: return {30'd0, m_en};
            8: return {30'd0, m_wk};
            9: return pv;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_match = 0; m_ctrl = 0; m_pre = 0;
            m_stat = 0; m_en = 0; m_wk = 0; m_pulse = 0; m_tog = 0;
            for (int i = 0; i < 5; i++) begin m_pend[i] = 0; m_pdata[i] = 0; end
        end else begin
            bit        cm [5];
            bit        tick, ovf, mt, ev, run;
            bit [31:0] nxt, n_cnt;
            bit [1:0]  ts, wv;
            int        divm1;
            run   = m_ctrl[0];
            divm1 = m_ctrl[5] ? (1 << (int'(m_ctrl[4:2]) + 1)) - 1 : 0;
            tick  = run && (m_pre >= divm1);
            ovf = 0; mt = 0; nxt = m_cnt;
            if (tick) begin
                if (m_cnt == 32'hFFFF_FFFF) begin
                    ovf = 1;
                    nxt = m_ctrl[1] ? m_load : 0;
                end else nxt = m_cnt + 1;
                mt = m_ctrl[6] && (nxt == m_match);
            end
            ts = m_ctrl[11:10];
            ev = (ts == 2'b01 && ovf) || (ts == 2'b10 && (ovf || mt));
            for (int i = 0; i < 5; i++) cm[i] = (m_pend[i] == 1);
            n_cnt = cm[4] ? m_load : (cm[1] ? m_pdata[1] : nxt);
            m_pulse = !run ? 0 : (tick ? ev : m_pulse);
            if (ts != 2'b01 && ts != 2'b10) m_tog = 0;
            else if (ev) m_tog = ~m_tog;
            m_pre = run ? (tick ? 0 : m_pre + 1) : 0;
            wv = bus_wdata[1:0];
            m_stat = (m_stat & ~((bus_wr && bus_addr == 5) ? wv : 2'b00)) | {ovf, mt};
            if (bus_wr && bus_addr == 6) m_en = wv;
            if (bus_wr && bus_addr == 7) m_en = m_en & ~wv;
            if (bus_wr && bus_addr == 8) m_wk = wv;
            if (cm[0]) m_ctrl = m_pdata[0][12:0];
            else if (ovf && !m_ctrl[1]) m_ctrl[0] = 0;
            if (cm[2]) m_load = m_pdata[2];
            if (cm[3]) m_match = m_pdata[3];
            m_cnt = n_cnt;
            for (int i = 0; i < 5; i++) begin
                if (m_pend[i] == 0 && bus_wr && bus_addr == i) begin
                    m_pend[i] = 2; m_pdata[i] = bus_wdata;
                end else if (m_pend[i] > 0) m_pend[i] = m_pend[i] - 1;
            end
        end
    end

    function automatic string tag_of(int a);
        case (a)
            0, 1: return "R3";
            2, 9: return "R2";
            3: return "R8";
            4: return "R7";
            8: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag_of(int'(bus_addr)), bus_rdata, m_read(int'(bus_addr)));
            chk("R9", {31'd0, irq_out}, {31'd0, |(m_stat & m_en)});
            chk("R10", {31'd0, wake_out}, {31'd0, |(m_stat & m_wk)});
            chk("R11", {31'd0, pwm_out}, {31'd0, m_pin()});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(int a, bit [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdx(int a, string tag, bit [31:0] exp);
        @(negedge clk); #1;
        bus_addr = 4'(a);
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic rdm(int a, string tag);
        @(negedge clk); #1;
        bus_addr = 4'(a);
        #1 chk(tag, bus_rdata, m_read(a));
    endtask

    initial begin
        bit [31:0] c1;
        int hi, lo, tr;
        bit last;
        idle(4);
        #1 rst_n = 1;
        // R1 reset values
        for (int a = 0; a < 10; a++) rdx(a, "R1", 0);
        chk("R1", {29'd0, irq_out, wake_out, pwm_out}, 0);

        // R2 posted write, second write while pending is lost
        wr(2, 32'h100);
        wr(2, 32'h200);
        idle(3);
        rdx(2, "R2", 32'h100);
        wr(3, 32'h40);
        rdx(9, "R2", 32'h8);
        idle(2);
        rdx(9, "R2", 0);

        // R7 trigger copies load
        wr(4, 32'hDEAD);
        idle(3);
        rdx(1, "R7", 32'h100);

        // R3 start / freeze
        wr(0, 32'h1);
        idle(10);
        wr(0, 32'h0);
        idle(4);
        rdm(1, "R3");
        c1 = bus_rdata;
        idle(6);
        rdx(1, "R3", c1);
        chk("R3", {31'd0, c1 > 32'h100}, 1);

        // R4 prescaler ratio 2 -> divide by 8
        wr(1, 0);
        wr(0, 32'h29);
        idle(80);
        rdm(1, "R4");
        wr(0, 0);
        idle(3);
        rdm(1, "R4");

        // R8 compare match with interrupt enabled
        wr(1, 0);
        wr(6, 3);
        wr(0, 32'h41);
        idle(80);
        rdx(5, "R8", 1);
        chk("R9", {31'd0, irq_out}, 1);

        // R9 acknowledge and disable
        wr(5, 1);
        rdx(5, "R9", 0);
        chk("R9", {31'd0, irq_out}, 0);
        wr(7, 1);
        rdx(6, "R9", 2);

        // R5 auto-reload overflow, pulse on overflow (R12)
        wr(0, 0);
        wr(2, 32'hFFFF_FFF0);
        wr(4, 0);
        wr(0, 32'h403);
        idle(8);
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (pwm_out) hi++;
        end
        chk("R12", {31'd0, hi >= 2 && hi <= 3}, 1);
        rdm(1, "R5");
        chk("R5", {31'd0, bus_rdata >= 32'hFFFF_FFF0}, 1);
        rdm(5, "R5");
        chk("R5", {31'd0, bus_rdata[1]}, 1);

        // R6 one-shot
        wr(0, 0);
        wr(1, 32'hFFFF_FFFA);
        wr(0, 1);
        idle(20);
        rdx(0, "R6", 0);
        rdx(1, "R6", 0);

        // R10 wakeup
        wr(8, 2);
        chk("R10", {31'd0, wake_out}, 1);
        wr(5, 3);
        chk("R10", {31'd0, wake_out}, 0);

        // R11 reserved select with high resting level: pin stays high
        wr(2, 32'hFFFF_FFF0);
        wr(4, 0);
        wr(0, 32'h0C83);
        idle(4);
        lo = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (!pwm_out) lo++;
        end
        chk("R11", lo, 0);

        // R12 toggle on overflow or match
        wr(3, 32'hFFFF_FFF8);
        wr(0, 32'h18C3);
        idle(4);
        tr = 0;
        last = pwm_out;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); #1;
            if (pwm_out != last) tr++;
            last = pwm_out;
        end
        chk("R12", {31'd0, tr >= 6}, 1);
        wr(0, 0);
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule